// File: doc/BRIEF.md
# Power-Good and Reset Supervisor

This block turns four per-channel "output above power-good level" comparator flags into four qualified power-good outputs and one active-low system reset. A channel's power-good output releases only after its comparator flag has stayed high, without a break, for a set number of timebase ticks. Any drop below the level pulls that output low again and restarts the channel's count from zero.

The system reset is held asserted until every channel picked by a 4-bit mask has been above its level for a full reset timeout, counted in ticks. While the manual-reset input is low, the reset is held asserted. When it returns high, a full timeout runs again before release. A picked channel that falls below its level asserts the reset in the same cycle and clears the timeout.

The 2-bit per-channel threshold codes are not used inside the block. They pass straight to the analog comparators that make the flags. The comparators and the threshold percentages are outside this block.

Top module: `pgr_supervisor`

## Requirements
- R1: While the synchronous reset `rst_n` is low, every bit of `pg_out` is 0 and `sys_rst_n` is 0.
- R2: Bit i of `pg_out` becomes 1 at the clock edge that samples the PG_QUAL_TICKS-th `tick` pulse counted while `above_thr[i]` has been continuously 1. Cycles without `tick` do not advance the count.
- R3: When `above_thr[i]` is 0 at a clock edge, `pg_out[i]` is 0 after that edge and the channel's qualification count restarts from zero.
- R4: Each channel qualifies independently. One channel's comparator flag has no effect on another channel's `pg_out` bit.
- R5: With `mr_n` high and every channel selected in `rst_mask` above its level, `sys_rst_n` becomes 1 at the edge that samples the RST_TIMEOUT_TICKS-th `tick` counted under that condition.
- R6: If a channel selected in `rst_mask` has `above_thr` at 0, `sys_rst_n` is 0 in that same cycle and the timeout count is cleared.
- R7: A channel whose `rst_mask` bit is 0 has no effect on `sys_rst_n`.
- R8: While `mr_n` is 0, `sys_rst_n` is 0. After `mr_n` returns to 1, `sys_rst_n` stays 0 until a full RST_TIMEOUT_TICKS ticks have been counted.
- R9: With `rst_mask` equal to 4'b0000, `sys_rst_n` depends only on `mr_n` and the timeout counted since the block left reset.
- R10: `lvl_code_out` equals `lvl_code_in`, packed two bits per channel with channel 1 in bits [1:0] and channel 4 in bits [7:6]. The code values are 00 = 95 %, 01 = 92.5 %, 10 = 90 % and 11 = 87.5 % of the channel's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that advances both kinds of timer |
| above_thr | input | 4 | Per-channel comparator flag: output above its power-good level |
| rst_mask | input | 4 | Channels that gate the system reset |
| mr_n | input | 1 | Manual reset, active low, already synchronous to clk |
| lvl_code_in | input | 8 | Per-channel 2-bit threshold codes from configuration |
| lvl_code_out | output | 8 | Threshold codes passed to the comparators |
| pg_out | output | 4 | Qualified power-good outputs, 1 = released |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Two things can land in the same cycle: a selected channel dropping, which clears the reset timeout and pulls the reset low, and that channel's own power-good output falling one edge later. The bench provokes this by lowering a masked channel just after an edge. It checks at the following falling edge that `sys_rst_n` is already low and that the power-good bit has not yet been clocked. A second overlap comes from the manual reset rising while all masked channels are good. The bench checks that the full timeout is counted again from that rise, not from the earlier channel qualification.

// File: rtl/pgr_pkg.sv
// Package: shared constants and helpers for the power-good/reset supervisor.
// Assumes a fixed channel count of four, matching the packed level-code field.
package pgr_pkg;
    localparam int unsigned NUM_CH   = 4;
    localparam int unsigned LVL_W    = 2;
    localparam int unsigned LVL_BUS  = NUM_CH * LVL_W;

    // Threshold code values, meaning is a fraction of the channel input
    typedef enum logic [LVL_W-1:0] {
        LVL_95P0 = 2'b00,
        LVL_92P5 = 2'b01,
        LVL_90P0 = 2'b10,
        LVL_87P5 = 2'b11
    } lvl_code_e;

    // True when every selected channel reports above-level
    function automatic logic masked_all_good(input logic [NUM_CH-1:0] flags,
                                             input logic [NUM_CH-1:0] mask);
        return &(flags | ~mask);
    endfunction
endpackage

// File: rtl/pgr_hold_timer.sv
// Module: pgr_hold_timer
// Counts tick pulses while a condition holds; raises done after LIMIT ticks.
// Any cycle with the condition low clears the count and done at the next edge.
// Assumes LIMIT >= 1 and that tick is a one-cycle pulse synchronous to clk.
module pgr_hold_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM      = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Qualification counter and done flag; restart on any drop of cond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!cond) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (tick && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
            if (cnt == LIM_LAST) begin
                done <= 1'b1;
            end
        end
    end

    // R2: release only follows a counted tick under the condition
    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(tick) && $past(cond)));

    // R2: counter never passes its limit, done implies the limit was reached
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LIM) && (!done || (cnt == LIM)));

    // R3: a low condition clears the window at the next edge
    a_r3_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (!done && (cnt == '0)));
endmodule

// File: rtl/pgr_reset_ctrl.sv
// Module: pgr_reset_ctrl
// Builds the system reset: masked channel flags and manual reset form the
// hold condition, a hold timer supplies the timeout, and a failed condition
// asserts reset combinationally in the same cycle.
// Assumes mr_n is already synchronous to clk.
module pgr_reset_ctrl
    import pgr_pkg::*;
#(
    parameter int unsigned TIMEOUT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] above_thr,
    input  logic [NUM_CH-1:0] rst_mask,
    input  logic              mr_n,
    output logic              sys_rst_n
);
    logic hold_ok;
    logic timed_out;

    // Hold condition: manual reset released and every masked channel good
    always_comb begin
        hold_ok = mr_n && masked_all_good(above_thr, rst_mask);
    end

    pgr_hold_timer #(.LIMIT(TIMEOUT)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (hold_ok),
        .done  (timed_out)
    );

    // Output gating: a failed condition overrides the timer at once
    always_comb begin
        sys_rst_n = timed_out && hold_ok && rst_n;
    end

    // R8: manual reset low keeps the system in reset
    a_r8_mr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |-> !sys_rst_n);

    // R6: reset release needs the condition to have held at the prior edge
    a_r6_release_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(hold_ok));

    generate
        if (TIMEOUT > 1) begin : g_mr_restart
            // R8: the cycle after manual reset rises is still in reset
            a_r8_full_timeout: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mr_n) |=> !sys_rst_n);
        end
    endgenerate
endmodule

// File: rtl/pgr_supervisor.sv
// Module: pgr_supervisor
// Top of the power-good and reset supervisor: one qualification timer per
// channel drives pg_out, a reset controller drives sys_rst_n, and the
// threshold codes pass through unchanged to the analog comparators.
// Assumes all inputs are synchronous to clk.
module pgr_supervisor
    import pgr_pkg::*;
#(
    parameter int unsigned PG_QUAL_TICKS     = 100,
    parameter int unsigned RST_TIMEOUT_TICKS = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_CH-1:0]   above_thr,
    input  logic [NUM_CH-1:0]   rst_mask,
    input  logic                mr_n,
    input  logic [LVL_BUS-1:0]  lvl_code_in,
    output logic [LVL_BUS-1:0]  lvl_code_out,
    output logic [NUM_CH-1:0]   pg_out,
    output logic                sys_rst_n
);
    // Threshold codes: configuration passed to the comparators
    always_comb begin
        lvl_code_out = lvl_code_in;
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            pgr_hold_timer #(.LIMIT(PG_QUAL_TICKS)) u_qual (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .cond  (above_thr[ch]),
                .done  (pg_out[ch])
            );
        end
    endgenerate

    pgr_reset_ctrl #(.TIMEOUT(RST_TIMEOUT_TICKS)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .above_thr (above_thr),
        .rst_mask  (rst_mask),
        .mr_n      (mr_n),
        .sys_rst_n (sys_rst_n)
    );

    // R1: reset state at the ports
    a_r1_reset_state: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (pg_out == '0) && !sys_rst_n);
endmodule

// File: tb/pgr_supervisor_tb.sv
`timescale 1ns/100ps
module pgr_supervisor_tb;
    localparam int unsigned QUAL = 3;
    localparam int unsigned TOUT = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [3:0] above_thr;
    logic [3:0] rst_mask;
    logic       mr_n;
    logic [7:0] lvl_code_in;
    logic [7:0] lvl_code_out;
    logic [3:0] pg_out;
    logic       sys_rst_n;

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    pgr_supervisor #(.PG_QUAL_TICKS(QUAL), .RST_TIMEOUT_TICKS(TOUT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .above_thr    (above_thr),
        .rst_mask     (rst_mask),
        .mr_n         (mr_n),
        .lvl_code_in  (lvl_code_in),
        .lvl_code_out (lvl_code_out),
        .pg_out       (pg_out),
        .sys_rst_n    (sys_rst_n)
    );

    // Vector fields: above[17:14] mask[13:10] mr[9] ticks[8:5] exp_pg[4:1] exp_rst[0]
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {4'b0000, 4'b1111, 1'b1, 4'd2, 4'b0000, 1'b0},  // R6 masked low
        {4'b1111, 4'b1111, 1'b1, 4'd2, 4'b0000, 1'b0},  // R2 partial
        {4'b1111, 4'b1111, 1'b1, 4'd1, 4'b1111, 1'b0},  // R2 release, R5 partial
        {4'b1111, 4'b1111, 1'b1, 4'd2, 4'b1111, 1'b1},  // R5 release
        {4'b1110, 4'b1111, 1'b1, 4'd1, 4'b1110, 1'b0},  // R3 R4 R6
        {4'b1111, 4'b1111, 1'b1, 4'd3, 4'b1111, 1'b0},  // R3 requal, R6 cleared
        {4'b1111, 4'b1110, 1'b1, 4'd2, 4'b1111, 1'b1},  // R5
        {4'b1110, 4'b1110, 1'b1, 4'd1, 4'b1110, 1'b1},  // R7 unmasked drop
        {4'b0110, 4'b1110, 1'b1, 4'd1, 4'b0110, 1'b0},  // R6 masked drop
        {4'b0110, 4'b0110, 1'b1, 4'd5, 4'b0110, 1'b1},  // R5 R7
        {4'b0110, 4'b0110, 1'b0, 4'd1, 4'b0110, 1'b0},  // R8 hold
        {4'b0110, 4'b0110, 1'b1, 4'd4, 4'b0110, 1'b0},  // R8 partial
        {4'b0110, 4'b0110, 1'b1, 4'd1, 4'b0110, 1'b1},  // R8 full timeout
        {4'b0000, 4'b0000, 1'b1, 4'd2, 4'b0000, 1'b1},  // R9 flags ignored
        {4'b0000, 4'b0000, 1'b0, 4'd1, 4'b0000, 1'b0},  // R9 mr only
        {4'b0000, 4'b0000, 1'b1, 4'd5, 4'b0000, 1'b1}   // R9 timeout
    };

    task automatic chk_pg(input string req, input logic [3:0] exp);
        checks++;
        if (pg_out !== exp) begin
            errors++;
            $display("FAIL %s pg_out actual=%b expected=%b", req, pg_out, exp);
        end
    endtask

    task automatic chk_rst(input string req, input logic exp);
        checks++;
        if (sys_rst_n !== exp) begin
            errors++;
            $display("FAIL %s sys_rst_n actual=%b expected=%b", req, sys_rst_n, exp);
        end
    endtask

    // Move to just after a rising edge, with no tick
    task automatic to_edge();
        tick = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // Clock n edges with a tick at each
    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(posedge clk);
            #1;
        end
        tick = 1'b0;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; above_thr = '0; rst_mask = 4'hF;
        mr_n = 1'b1; lvl_code_in = '0;
        repeat (3) @(posedge clk);
        #1;
        above_thr = 4'hF;
        run_ticks(4);
        @(negedge clk);
        chk_pg("R1", 4'b0000);
        chk_rst("R1", 1'b0);
        to_edge();
        above_thr = '0;
        rst_n = 1'b1;

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            above_thr = VEC[v][17:14];
            rst_mask  = VEC[v][13:10];
            mr_n      = VEC[v][9];
            run_ticks(int'(VEC[v][8:5]));
            @(negedge clk);
            chk_pg($sformatf("R2/R3/R4 vector %0d", v), VEC[v][4:1]);
            chk_rst($sformatf("R5-R9 vector %0d", v), VEC[v][0]);
            to_edge();
        end

        // Directed: qualification window restart (R3)
        rst_n = 1'b0; above_thr = '0; rst_mask = '0; mr_n = 1'b1;
        to_edge(); to_edge();
        rst_n = 1'b1;
        above_thr = 4'b0010;
        run_ticks(2);
        above_thr = 4'b0000;
        run_ticks(1);
        above_thr = 4'b0010;
        run_ticks(2);
        @(negedge clk);
        chk_pg("R3 window restarted", 4'b0000);
        to_edge();
        run_ticks(1);
        @(negedge clk);
        chk_pg("R3 requalified", 4'b0010);
        chk_rst("R9 empty mask timeout", 1'b1);

        // Directed: no tick, no progress (R2)
        to_edge();
        above_thr = 4'b1111;
        repeat (10) to_edge();
        @(negedge clk);
        chk_pg("R2 no tick", 4'b0010);

        // Directed: masked drop seen in the same cycle (R6)
        to_edge();
        above_thr = 4'b0011;
        rst_mask  = 4'b0001;
        to_edge();
        @(negedge clk);
        chk_rst("R6 masked good", 1'b1);
        to_edge();
        above_thr = 4'b0010;
        @(negedge clk);
        chk_rst("R6 same cycle", 1'b0);
        chk_pg("R4 untouched channel", 4'b0010);

        // Directed: threshold code pass-through (R10)
        to_edge();
        lvl_code_in = {2'b11, 2'b10, 2'b01, 2'b00};
        @(negedge clk);
        checks++;
        if (lvl_code_out !== 8'b11_10_01_00) begin
            errors++;
            $display("FAIL R10 lvl_code_out actual=%b expected=%b", lvl_code_out, 8'b11100100);
        end
        checks++;
        if (lvl_code_out[7:6] !== 2'b11) begin
            errors++;
            $display("FAIL R10 channel 4 code actual=%b expected=11", lvl_code_out[7:6]);
        end

        summary();
    end
endmodule